// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block is the digital serial side of a telephony voice codec. It shares one master bit clock with the frame syncs that drive it, so no synchronizer sits on any input. In the transmit direction, a byte is handed over on a valid/ready stream and held until the next transmit frame sync opens an 8-bit slot. The byte is then shifted out MSB first on a serial pin. The pin carries an output enable, so a board-level tri-state buffer can release the shared PCM highway between slots. An active-low slot strobe tracks the same window.

In the receive direction, a separate frame sync opens a slot. Eight serial bits are captured MSB first and presented as a parallel byte with a single valid pulse. Serial bits are launched on rising clock edges. Frame syncs and serial input are sampled on falling edges. The driver lets go of the highway at the falling edge inside the last bit, which leaves half a bit period of turnaround before the next slot owner drives it.

The transmit stream is the only place where the block applies back-pressure. It holds one byte and lowers `tx_ready` until a slot has taken that byte. The receive stream has no ready input. A consumer must take `rx_byte` in the cycle in which `rx_valid` is high, although the byte stays on the port until the next slot completes. A power-down input parks both directions.

Top module: `pcm_slot_port`

## Requirements
- R1: `tx_ready` is high while the one-byte holding register is empty. A byte is accepted on a rising edge that sees `tx_valid` and `tx_ready` both high. After that, `tx_ready` stays low, and `tx_valid` and `tx_byte` have no effect, until a slot loads the byte. `tx_ready` then rises again.
- R2: A transmit frame sync is detected on the falling edge at which `tx_fs` is sampled high after it was sampled low at the previous falling edge. On the next rising edge, `ser_oe` goes high, `slot_strobe_n` goes low and `ser_out` shows bit 1.
- R3: A slot carries exactly 8 bits (SLOT_BITS), MSB first. Each bit is launched on the rising edge that begins its bit period.
- R4: `ser_oe` falls and `slot_strobe_n` rises on the falling edge in the middle of the 8th bit.
- R5: If the holding register is empty when a transmit slot opens, the slot sends the idle code 8'hFF (IDLE_CODE).
- R6: After a receive frame sync is detected (the same falling-edge rule as R2, applied to `rx_fs`), the next 8 falling edges sample `ser_in` MSB first. On the 8th of those edges, `rx_byte` is updated and `rx_valid` goes high for exactly one clock period. `rx_byte` then holds its value until the next slot completes.
- R7: A frame-sync rising edge detected while a slot of the same direction is in progress is ignored. No second slot follows.
- R8: While `pwr_down` is high, frame syncs are ignored, and a slot in progress is abandoned within one clock: `ser_oe` goes low, `slot_strobe_n` goes high and no `rx_valid` is produced. After release, the next frame sync starts a normal slot.
- R9: In reset (`rst_n` low), `ser_oe`=0, `slot_strobe_n`=1, `tx_ready`=1, `rx_valid`=0 and `rx_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Parks both directions while high |
| tx_fs | input | 1 | Transmit frame sync |
| tx_byte | input | SLOT_BITS | Byte offered to the transmit stream |
| tx_valid | input | 1 | `tx_byte` is valid |
| tx_ready | output | 1 | Holding register can accept a byte |
| ser_out | output | 1 | Serial transmit bit (0 while disabled) |
| ser_oe | output | 1 | Drive enable for `ser_out`; low means high impedance |
| slot_strobe_n | output | 1 | Active-low transmit slot strobe |
| rx_fs | input | 1 | Receive frame sync |
| ser_in | input | 1 | Serial receive bit |
| rx_byte | output | SLOT_BITS | Last received byte |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` is new |

## Verification
A bit counter that is off by one shows up within a single slot. The enable then drops half a bit early or late, or a ninth bit appears on the pin, and the bench sees this at the half-period samples around the last bit. A holding flag stuck in the wrong state shows up at the next slot: either the idle code replaces the queued byte, or `tx_ready` never rises again. A receive shifter that is left active shows up as a second valid pulse or a byte shifted by one, and this is caught on the frame in which it happens.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int unsigned SLOT_BITS_DEF = 8;
  localparam logic [SLOT_BITS_DEF-1:0] IDLE_CODE_DEF = 8'hFF;
endpackage

// File: rtl/pcm_fs_edge.sv
module pcm_fs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_in,
  output logic fs_rise
);
  logic fs_q;

  // frame sync level is sampled on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fs_in;
  end

  assign fs_rise = fs_in & ~fs_q;
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pd,
  input  logic         fs_rise,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         ser_out,
  output logic         ser_oe,
  output logic         strobe_n
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          arm, cut;
  logic          active, full;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg, hold;
  logic          start;

  assign start = arm & ~active & ~pd;

  // falling-edge side: slot request and mid-bit release
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm <= 1'b0;
      cut <= 1'b0;
    end else begin
      if (pd || active)            arm <= 1'b0;
      else if (fs_rise)            arm <= 1'b1;
      if (!active)                 cut <= 1'b0;
      else if (cnt == LAST)        cut <= 1'b1;
    end
  end

  // rising-edge side: bit launch and holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      hold   <= '0;
      full   <= 1'b0;
    end else begin
      if (pd) begin
        active <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= full ? hold : IDLE;
      end else if (active) begin
        if (cnt == LAST) active <= 1'b0;
        else begin
          cnt   <= cnt + 1'b1;
          shreg <= {shreg[W-2:0], 1'b0};
        end
      end
      if (tx_valid && !full) begin
        hold <= tx_byte;
        full <= 1'b1;
      end else if (start) begin
        full <= 1'b0;
      end
    end
  end

  assign tx_ready = ~full;
  assign ser_oe   = active & ~cut;
  assign ser_out  = ser_oe & shreg[W-1];
  assign strobe_n = ~ser_oe;

  assert_accept_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  assert_sync_opens_slot_R2: assert property (@(posedge clk) disable iff (!rst_n || pd)
    (arm && !active) |=> ser_oe);
  assert_release_in_last_bit_R4: assert property (@(negedge clk) disable iff (!rst_n || pd)
    $fell(ser_oe) |-> (cnt == LAST) || $past(pd));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pd,
  input  logic         fs_rise,
  input  logic         ser_in,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (pd) begin
        active <= 1'b0;
      end else if (active) begin
        shreg <= {shreg[W-2:0], ser_in};
        if (cnt == LAST) begin
          active   <= 1'b0;
          rx_byte  <= {shreg[W-2:0], ser_in};
          rx_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fs_rise) begin
        active <= 1'b1;
        cnt    <= '0;
      end
    end
  end

  assert_valid_one_cycle_R6: assert property (@(negedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_pd_parks_rx_R8: assert property (@(negedge clk) disable iff (!rst_n)
    pd |=> (!active && !rx_valid));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
  parameter logic [SLOT_BITS-1:0] IDLE_CODE = IDLE_CODE_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_down,
  input  logic                 tx_fs,
  input  logic [SLOT_BITS-1:0] tx_byte,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic                 ser_out,
  output logic                 ser_oe,
  output logic                 slot_strobe_n,
  input  logic                 rx_fs,
  input  logic                 ser_in,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  logic tx_rise, rx_rise;

  pcm_fs_edge u_tx_edge (.clk(clk), .rst_n(rst_n), .fs_in(tx_fs), .fs_rise(tx_rise));
  pcm_fs_edge u_rx_edge (.clk(clk), .rst_n(rst_n), .fs_in(rx_fs), .fs_rise(rx_rise));

  pcm_tx_slot #(.W(SLOT_BITS), .IDLE(IDLE_CODE)) u_tx (
    .clk(clk), .rst_n(rst_n), .pd(pwr_down), .fs_rise(tx_rise),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ser_out(ser_out), .ser_oe(ser_oe), .strobe_n(slot_strobe_n)
  );

  pcm_rx_slot #(.W(SLOT_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .pd(pwr_down), .fs_rise(rx_rise),
    .ser_in(ser_in), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );
endmodule

// File: tb/pcm_slot_port_bench.sv
module pcm_slot_port_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, pwr_down = 1'b0, tx_fs = 1'b0, tx_valid = 1'b0;
  logic rx_fs = 1'b0, ser_in = 1'b0;
  logic [W-1:0] tx_byte = '0;
  logic tx_ready, ser_out, ser_oe, slot_strobe_n, rx_valid;
  logic [W-1:0] rx_byte;

  pcm_slot_port u_pcm_slot_port (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .tx_fs(tx_fs),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ser_out(ser_out), .ser_oe(ser_oe), .slot_strobe_n(slot_strobe_n),
    .rx_fs(rx_fs), .ser_in(ser_in), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit mon_en = 1'b0;
  logic [W-1:0] tx_q[$];
  int           tx_t[$];
  logic [W-1:0] rx_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drv_edge();
    @(posedge clk); #2;
  endtask

  task automatic load(input logic [W-1:0] b);
    do drv_edge(); while (!tx_ready);
    tx_byte = b; tx_valid = 1'b1;
    drv_edge();
    tx_valid = 1'b0;
    chk(!tx_ready, "R1", "ready after accept", tx_ready, 0);
  endtask

  task automatic tx_frame(input logic [W-1:0] exp, input bit retrig);
    drv_edge();
    tx_fs = 1'b1; tx_q.push_back(exp); tx_t.push_back(cyc + 1);
    drv_edge(); tx_fs = 1'b0;
    if (retrig) begin
      drv_edge(); drv_edge();
      tx_fs = 1'b1;                 // R7: edge in the middle of the slot
      drv_edge(); tx_fs = 1'b0;
    end
    repeat (W + 3) drv_edge();
  endtask

  task automatic rx_frame(input logic [W-1:0] b, input bit retrig);
    drv_edge();
    rx_fs = 1'b1; rx_q.push_back(b);
    for (int i = 0; i < W; i++) begin
      drv_edge();
      if (i == 0) rx_fs = 1'b0;
      if (retrig && i == 3) rx_fs = 1'b1;   // R7 on the receive side
      if (retrig && i == 4) rx_fs = 1'b0;
      ser_in = b[W-1-i];
    end
    repeat (4) drv_edge();
  endtask

  // transmit monitor: R2 start cycle, R3 bits, R4 mid-bit release
  always begin
    @(posedge clk); #3;
    if (mon_en && ser_oe) begin
      automatic int st = cyc;
      automatic logic [W-1:0] got = '0;
      automatic bit win_ok = 1'b1;
      got[W-1] = ser_out;
      win_ok &= !slot_strobe_n;
      for (int i = 1; i < W; i++) begin
        @(posedge clk); #3;
        win_ok &= ser_oe & !slot_strobe_n;
        got[W-1-i] = ser_out;
      end
      chk(win_ok, "R3", "enable/strobe held over 8 bits", win_ok, 1);
      #4;
      chk(!ser_oe && slot_strobe_n, "R4", "release mid bit 8",
          {ser_oe, slot_strobe_n}, 2'b01);
      if (tx_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected transmit slot", got, 0);
      end else begin
        automatic logic [W-1:0] eb = tx_q.pop_front();
        automatic int et = tx_t.pop_front();
        chk(st == et, "R2", "slot start cycle", st, et);
        chk(got == eb, "R3", "transmit byte", got, eb);
      end
    end
  end

  // receive monitor: R6
  always begin
    @(posedge clk); #3;
    if (mon_en && rx_valid) begin
      if (rx_q.size() == 0) chk(1'b0, "R6", "unexpected rx_valid", rx_byte, 0);
      else begin
        automatic logic [W-1:0] eb = rx_q.pop_front();
        chk(rx_byte == eb, "R6", "received byte", rx_byte, eb);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) drv_edge();
    // R9
    chk(!ser_oe && slot_strobe_n && tx_ready && !rx_valid && rx_byte == 0,
        "R9", "reset outputs", {ser_oe, slot_strobe_n, tx_ready, rx_valid}, 4'b0110);
    rst_n = 1'b1;
    repeat (2) drv_edge();
    mon_en = 1'b1;

    // R1 R2 R3 R4 with several patterns
    load(8'hA5); tx_frame(8'hA5, 0);
    chk(tx_ready, "R1", "ready back after slot", tx_ready, 1);
    load(8'h80); tx_frame(8'h80, 0);
    load(8'h01); tx_frame(8'h01, 0);

    // R1: offers while full are ignored
    load(8'h3C);
    tx_byte = 8'h11; tx_valid = 1'b1;
    drv_edge(); drv_edge();
    tx_valid = 1'b0;
    chk(!tx_ready, "R1", "ready stays low while full", tx_ready, 0);
    tx_frame(8'h3C, 0);

    // R5: empty holding register
    tx_frame(8'hFF, 0);

    // R6 receive patterns
    rx_frame(8'h5A, 0);
    rx_frame(8'h00, 0);
    rx_frame(8'hC3, 0);
    chk(rx_byte == 8'hC3, "R6", "rx_byte held", rx_byte, 8'hC3);

    // R7 both directions, then both at once
    load(8'h69);
    fork
      tx_frame(8'h69, 1);
      rx_frame(8'h96, 1);
    join

    // R8: power-down abandons slots and ignores syncs
    mon_en = 1'b0;
    drv_edge(); tx_fs = 1'b1; rx_fs = 1'b1;
    drv_edge(); tx_fs = 1'b0; rx_fs = 1'b0;
    drv_edge(); drv_edge();
    pwr_down = 1'b1;
    @(posedge clk); #3;
    chk(!ser_oe && slot_strobe_n, "R8", "slot abandoned", {ser_oe, slot_strobe_n}, 2'b01);
    begin
      automatic bit quiet = 1'b1;
      for (int i = 0; i < 24; i++) begin
        @(posedge clk); #2;
        if (i % 6 == 1) begin tx_fs = 1'b1; rx_fs = 1'b1; end
        if (i % 6 == 2) begin tx_fs = 1'b0; rx_fs = 1'b0; end
        #1; quiet &= !ser_oe & slot_strobe_n & !rx_valid;
        #4; quiet &= !ser_oe & !rx_valid;
      end
      chk(quiet, "R8", "syncs ignored in power-down", quiet, 1);
    end
    drv_edge(); pwr_down = 1'b0;
    repeat (3) drv_edge();
    mon_en = 1'b1;
    load(8'hE7);
    fork
      tx_frame(8'hE7, 0);
      rx_frame(8'h7E, 0);
    join

    repeat (4) drv_edge();
    chk(tx_q.size() == 0, "R3", "all transmit slots seen", tx_q.size(), 0);
    chk(rx_q.size() == 0, "R6", "all received bytes seen", rx_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule